// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches six modem and line status sources of one serial channel: break/abort, transmit underrun/end-of-message, CTS, sync/hunt, DCD and baud-counter zero. Each raw level passes through a synchroniser. A rising or falling edge on any source whose enable bit is set latches a single status-change event. While that event is pending, the six edge-sensitive bits of the status byte keep the levels captured when the event was taken. Software therefore reads the condition that caused the interrupt, not a later one. A clear command releases the latch, and the status bits then follow the live levels again.

The block also builds the combined interrupt-pending byte for a two-channel device. The local channel's receive and transmit flags and its status-change flag are placed next to the three flags of the peer channel in a fixed layout. The status-change request reaches the interrupt output only when both the channel's status interrupt enable and the device's master interrupt enable are set. Vector generation and priority chaining are left to other logic.

Top module: `esc_latch`

## Requirements
- R1: After reset, the latch is clear and every synchroniser and edge register holds 0. With all inputs at 0, `statusByte`, `pendByte` and `irqReq` are all 0.
- R2: `statusByte` is laid out as: bit 7 break/abort, bit 6 underrun/EOM, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 2 `txEmpty`, bit 1 zero count, bit 0 `rxReady`. On `srcRaw`, index 5 down to 0 carries break, underrun, CTS, sync/hunt, DCD and zero count.
- R3: A change on `srcRaw` shows in `statusByte` after SYNC_STAGES rising clock edges. The latch it causes shows one edge later.
- R4: A rising or falling edge on a source sets the latch only when that source's enable bit is 1. The enable bits in `enableReg` are: bit 7 break, bit 6 underrun, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 1 zero count. Bits 2 and 0 of `enableReg` have no effect, and the latch never sets without an edge.
- R5: While the latch is set, status bits 7:3 and 1 hold the levels sampled on the edge that set it. Later edges neither change them nor create a second event. Bits 2 and 0 stay live.
- R6: A clear command is `cmdValid` high with `cmdCode[5:3]` equal to 3'b010 (for example 8'h10). The other bits of `cmdCode` are ignored. Other codes, and codes without `cmdValid`, have no effect. If an enabled edge arrives in the same cycle as a clear command, the edge wins: the latch stays set and recaptures the levels.
- R7: The local status-pending flag is the latch ANDed with `statIe`. `irqReq` is that flag ANDed with `masterIe`.
- R8: `pendByte` with LOCAL_IS_A=1 is laid out as: bit 5 local receive, bit 4 local transmit, bit 3 local status, bit 2 peer receive, bit 1 peer transmit, bit 0 peer status. With LOCAL_IS_A=0 the two 3-bit groups swap places. Bits 7:6 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcRaw | input | 6 | Unsynchronised source levels (R2 order) |
| txEmpty | input | 1 | Live transmit-buffer-empty level |
| rxReady | input | 1 | Live receive-character-ready level |
| enableReg | input | 8 | Per-source change enables |
| statIe | input | 1 | Channel status interrupt enable |
| masterIe | input | 1 | Device master interrupt enable |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 8 | Command byte |
| localRxPend | input | 1 | Local receive interrupt pending |
| localTxPend | input | 1 | Local transmit interrupt pending |
| peerRxPend | input | 1 | Peer receive interrupt pending |
| peerTxPend | input | 1 | Peer transmit interrupt pending |
| peerStatPend | input | 1 | Peer status interrupt pending |
| statusByte | output | 8 | Status byte, frozen edge bits while pending |
| pendByte | output | 8 | Combined pending byte of both channels |
| irqReq | output | 1 | Status-change interrupt request |

## Verification
The bench builds the block with SYNC_STAGES=2 and LOCAL_IS_A=1. These settings put the local channel's three flags in bits 5:3 of the pending byte and the peer channel's flags in bits 2:0. They also make the latency short enough to count: a source change reaches the status byte after two edges and the pending byte after three. That timing lets the bench place a clear command exactly in the cycle in which an edge is detected, which tests the set-over-clear priority and the recapture of the levels.

// File: rtl/esc_pkg.sv
package esc_pkg;

  localparam int NUM_SRC = 6;

  // command field value (bits 5:3) that releases the change latch
  localparam logic [2:0] CLR_FIELD = 3'b010;

  typedef struct packed {
    logic capture;   // load the snapshot from the synchronised levels
    logic frozen;    // latch set: present the snapshot
    logic statPend;  // latch gated by the channel status enable
  } escStrobe_t;

  // gather the per-source enables from the enable byte, in srcRaw order
  function automatic logic [NUM_SRC-1:0] enableSel(input logic [7:0] reg8);
    return {reg8[7:3], reg8[1]};
  endfunction

endpackage

// File: rtl/esc_datapath.sv
module esc_datapath
  import esc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit LOCAL_IS_A  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  logic               txEmpty,
  input  logic               rxReady,
  input  logic [7:0]         enableReg,
  input  escStrobe_t         strobe,
  input  logic               localRxPend,
  input  logic               localTxPend,
  input  logic               peerRxPend,
  input  logic               peerTxPend,
  input  logic               peerStatPend,
  output logic               edgeHit,
  output logic [7:0]         statusByte,
  output logic [7:0]         pendByte
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES];
  logic [NUM_SRC-1:0] syncLvl;
  logic [NUM_SRC-1:0] prevLvl;
  logic [NUM_SRC-1:0] snapLvl;
  logic [NUM_SRC-1:0] edgeVec;
  logic [NUM_SRC-1:0] shownLvl;

  // synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
    end else begin
      syncStage[0] <= srcRaw;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
    end
  end

  assign syncLvl = syncStage[LAST];

  // edge history and the snapshot shown while an event is pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      snapLvl <= '0;
    end else begin
      prevLvl <= syncLvl;
      if (strobe.capture) snapLvl <= syncLvl;
    end
  end

  assign edgeVec  = (syncLvl ^ prevLvl) & enableSel(enableReg);
  assign edgeHit  = |edgeVec;
  assign shownLvl = strobe.frozen ? snapLvl : syncLvl;

  assign statusByte = {shownLvl[5:1], txEmpty, shownLvl[0], rxReady};

  // pending byte: channel A group in bits 5:3, channel B group in bits 2:0
  logic [2:0] localGrp;
  logic [2:0] peerGrp;
  assign localGrp = {localRxPend, localTxPend, strobe.statPend};
  assign peerGrp  = {peerRxPend, peerTxPend, peerStatPend};

  generate
    if (LOCAL_IS_A) begin : g_localA
      assign pendByte = {2'b00, localGrp, peerGrp};
    end else begin : g_localB
      assign pendByte = {2'b00, peerGrp, localGrp};
    end
  endgenerate

endmodule

// File: rtl/esc_control.sv
module esc_control
  import esc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       edgeHit,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       statIe,
  output escStrobe_t strobe
);

  logic latched;
  logic clrHit;

  assign clrHit = cmdValid && (cmdCode[5:3] == CLR_FIELD);

  // a detected edge outranks a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        latched <= 1'b0;
    else if (edgeHit) latched <= 1'b1;
    else if (clrHit)  latched <= 1'b0;
  end

  assign strobe.capture  = edgeHit && (!latched || clrHit);
  assign strobe.frozen   = latched;
  assign strobe.statPend = latched && statIe;

endmodule

// File: rtl/esc_latch.sv
module esc_latch
  import esc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit LOCAL_IS_A  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] srcRaw,
  input  logic       txEmpty,
  input  logic       rxReady,
  input  logic [7:0] enableReg,
  input  logic       statIe,
  input  logic       masterIe,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       localRxPend,
  input  logic       localTxPend,
  input  logic       peerRxPend,
  input  logic       peerTxPend,
  input  logic       peerStatPend,
  output logic [7:0] statusByte,
  output logic [7:0] pendByte,
  output logic       irqReq
);

  escStrobe_t ctrlStrobe;
  logic       edgeHit;
  logic       latchedNow;

  esc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeHit  (edgeHit),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .statIe   (statIe),
    .strobe   (ctrlStrobe)
  );

  esc_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .LOCAL_IS_A  (LOCAL_IS_A)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .srcRaw       (srcRaw),
    .txEmpty      (txEmpty),
    .rxReady      (rxReady),
    .enableReg    (enableReg),
    .strobe       (ctrlStrobe),
    .localRxPend  (localRxPend),
    .localTxPend  (localTxPend),
    .peerRxPend   (peerRxPend),
    .peerTxPend   (peerTxPend),
    .peerStatPend (peerStatPend),
    .edgeHit      (edgeHit),
    .statusByte   (statusByte),
    .pendByte     (pendByte)
  );

  assign latchedNow = ctrlStrobe.frozen;
  assign irqReq     = ctrlStrobe.statPend && masterIe;

endmodule

// File: rtl/esc_latch_checker.sv
module esc_latch_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [7:0] cmdCode,
  input logic       edgeHit,
  input logic       latched,
  input logic [7:0] statusByte,
  input logic       irqReq,
  input logic       statIe,
  input logic       masterIe
);

  logic clrSeen;
  assign clrSeen = cmdValid && (cmdCode[5:3] == 3'b010);

  // R4: an enabled edge always leaves the latch set
  assert_set_on_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> latched);

  // R4: no event appears without an edge
  assert_no_spont_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!latched && !edgeHit) |=> !latched);

  // R6: a clear with no competing edge releases the latch
  assert_clear_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !edgeHit && clrSeen) |=> !latched);

  // R5: without a clear the latch holds and the edge bits stay frozen
  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !clrSeen) |=> (latched && $stable({statusByte[7:3], statusByte[1]})));

  // R7: the request needs both enables and a pending event
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (masterIe && statIe && latched));

endmodule

bind esc_latch esc_latch_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .edgeHit    (edgeHit),
  .latched    (latchedNow),
  .statusByte (statusByte),
  .irqReq     (irqReq),
  .statIe     (statIe),
  .masterIe   (masterIe)
);

// File: tb/esc_latch_bench.sv
module esc_latch_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] srcRaw = '0;
  logic       txEmpty = 1'b0;
  logic       rxReady = 1'b0;
  logic [7:0] enableReg = '0;
  logic       statIe = 1'b0;
  logic       masterIe = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic       localRxPend = 1'b0;
  logic       localTxPend = 1'b0;
  logic       peerRxPend = 1'b0;
  logic       peerTxPend = 1'b0;
  logic       peerStatPend = 1'b0;
  logic [7:0] statusByte;
  logic [7:0] pendByte;
  logic       irqReq;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  esc_latch #(.SYNC_STAGES(2), .LOCAL_IS_A(1'b1)) u_esc_latch (
    .clk(clk), .rstN(rstN), .srcRaw(srcRaw), .txEmpty(txEmpty), .rxReady(rxReady),
    .enableReg(enableReg), .statIe(statIe), .masterIe(masterIe),
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .localRxPend(localRxPend), .localTxPend(localTxPend),
    .peerRxPend(peerRxPend), .peerTxPend(peerTxPend), .peerStatPend(peerStatPend),
    .statusByte(statusByte), .pendByte(pendByte), .irqReq(irqReq)
  );

  typedef struct packed {
    logic [5:0] src;
    logic       txE;
    logic       rxR;
    logic [7:0] en;
    logic       sie;
    logic       mie;
    logic [2:0] peer;   // {rx, tx, status}
    logic [1:0] loc;    // {rx, tx}
    logic       clr;
    logic [7:0] expStat;
    logic [7:0] expPend;
    logic       expIrq;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{6'b000000, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'h05, 8'h00, 1'b0}, // R2 live bits
    '{6'b001000, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'h25, 8'h08, 1'b1}, // R4 CTS rise
    '{6'b001010, 1'b0, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'h21, 8'h08, 1'b1}, // R5 DCD frozen
    '{6'b001010, 1'b0, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b1, 8'h29, 8'h00, 1'b0}, // R6 clear
    '{6'b101010, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'hA9, 8'h00, 1'b0}, // R4 disabled
    '{6'b101011, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'hAF, 8'h00, 1'b0}, // R4 bits 2,0
    '{6'b101010, 1'b1, 1'b1, 8'hFA, 1'b0, 1'b1, 3'b000, 2'b00, 1'b0, 8'hAD, 8'h00, 1'b0}, // R7 fall, sie off
    '{6'b101010, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'hAD, 8'h08, 1'b1}, // R7 sie on
    '{6'b101010, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b0, 3'b000, 2'b00, 1'b0, 8'hAD, 8'h08, 1'b0}, // R7 mie off
    '{6'b101010, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b101, 2'b11, 1'b0, 8'hAD, 8'h3D, 1'b1}, // R8 layout
    '{6'b101010, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b1, 8'hAD, 8'h00, 1'b0}, // R6 clear
    '{6'b111010, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'hED, 8'h08, 1'b1}, // R4 underrun
    '{6'b111110, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b0, 8'hED, 8'h08, 1'b1}, // R5 second edge
    '{6'b111110, 1'b1, 1'b1, 8'hFA, 1'b1, 1'b1, 3'b000, 2'b00, 1'b1, 8'hFD, 8'h00, 1'b0}  // R5 no new event
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseCmd(input logic valid, input logic [7:0] code);
    cmdValid = valid;
    cmdCode  = code;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = '0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    waitNeg(3);
    check("R1 status", statusByte, 8'h00);
    check("R1 pend", pendByte, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
    rstN = 1'b1;
    waitNeg(3);
    check("R1 after release", pendByte, 8'h00);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      srcRaw    = VECS[v].src;
      txEmpty   = VECS[v].txE;
      rxReady   = VECS[v].rxR;
      enableReg = VECS[v].en;
      statIe    = VECS[v].sie;
      masterIe  = VECS[v].mie;
      {peerRxPend, peerTxPend, peerStatPend} = VECS[v].peer;
      {localRxPend, localTxPend} = VECS[v].loc;
      if (VECS[v].clr) pulseCmd(1'b1, 8'h10);
      else             @(negedge clk);
      waitNeg(4);
      check($sformatf("R2/R4-R8 vec%0d status", v), statusByte, VECS[v].expStat);
      check($sformatf("R4-R8 vec%0d pend", v), pendByte, VECS[v].expPend);
      check($sformatf("R7 vec%0d irq", v), {7'd0, irqReq}, {7'd0, VECS[v].expIrq});
    end

    // R3: latency of a DCD fall (state: src 111110, latch clear)
    srcRaw = 6'b111100;
    waitNeg(1);
    check("R3 one edge", statusByte, 8'hFD);
    waitNeg(1);
    check("R3 two edges status", statusByte, 8'hF5);
    check("R3 two edges pend", pendByte, 8'h00);
    waitNeg(1);
    check("R3 three edges pend", pendByte, 8'h08);

    // R6: non-clear codes and missing strobe
    pulseCmd(1'b1, 8'h38);
    waitNeg(1);
    check("R6 other code", pendByte, 8'h08);
    pulseCmd(1'b0, 8'h10);
    waitNeg(1);
    check("R6 no strobe", pendByte, 8'h08);
    pulseCmd(1'b1, 8'h12);
    check("R6 low bits ignored", pendByte, 8'h00);

    // R6: edge and clear in the same cycle
    srcRaw = 6'b111101;
    waitNeg(4);
    check("R6 setup latch", pendByte, 8'h08);
    check("R5 setup frozen", statusByte, 8'hF7);
    srcRaw = 6'b111111;
    waitNeg(2);
    pulseCmd(1'b1, 8'h10);
    check("R6 edge wins pend", pendByte, 8'h08);
    check("R6 edge recapture", statusByte, 8'hFF);
    pulseCmd(1'b1, 8'h50);
    check("R6 final clear", pendByte, 8'h00);

    finishRun();
  end

endmodule